// File: doc/BRIEF.md
# Prescaled Real-Time Counter

This block is a wall-clock style counter for a system that keeps time from a slow source. The slow clock arrives as a single-cycle enable pulse, `tick_in`, in the bus clock domain. Each enabled tick advances a 16-bit prescaler. The prescaler produces a count step once every 2^k ticks, where software picks k from 0 to 15. Each step advances a 32-bit count. When the count equals a programmable ceiling, the next step returns it to zero and raises a wrap event.

Software uses a simple register bus with select, write strobe, a byte address, and write and read data. Through it software sets up the prescaler, starts and stops counting, reads and loads the count, and sets the ceiling. The wrap event sets a sticky status flag. That flag drives `irq` through a mask that is controlled by separate set, clear and view registers. The status flag itself is cleared by writing one to a clear register.

Top module: `rtc_prescaled`

## Requirements
- R1: After reset, the control register reads 0x00010000 (clock enable at bit 16 set, run bit 0 clear, divider select bits [11:8] zero). The ceiling reads 0xFFFFFFFF, the count, mask and status read 0, and `irq` is 0.
- R2: Every tick while bit 16 is set advances a 16-bit prescaler. A count step occurs on a tick whose pre-increment prescaler value has its low k bits all ones, where k is control bits [11:8]. A step advances the count (0x04) only while run bit 0 is set. With k=0, every tick is a step.
- R3: With clock enable (bit 16) clear, or run (bit 0) clear, ticks leave the count unchanged.
- R4: A step taken while the count equals the ceiling (0x08) loads the count with 0 and sets status bit 0 (0x1C). This also holds for a ceiling of 0xFFFFFFFF.
- R5: The ceiling register at 0x08 is written and read back as a full 32-bit value.
- R6: A bus write to the count at 0x04 takes effect even if a step occurs in the same cycle. The step is then lost, and no wrap event is raised.
- R7: Writing one to bit 0 at 0x10 sets mask bit 0, and writing one to bit 0 at 0x14 clears it. Writing zero to either has no effect. The mask reads at 0x18.
- R8: Writing one to bit 0 at 0x20 clears status bit 0, and writing zero has no effect. If a wrap occurs in the same cycle as the clear, the status stays set.
- R9: `irq` is high exactly when status bit 0 and mask bit 0 are both set.
- R10: Reads at 0x10, 0x14, 0x20 and at any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Slow-clock enable pulse, one cycle per source edge |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, from bus_addr) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit count and a 16-bit prescaler with a 4-bit divider select. A ceiling of 5 brings several wraps into a few dozen ticks. Loading the count just below 0xFFFFFFFF covers the all-ones ceiling without a long run. A divider select of 3, driven with both continuous and sparse tick patterns, exercises the prescaler tap. Cycle-aligned bus writes made together with ticks reach the write-versus-step and wrap-versus-clear collisions.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_VAL  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TOP  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IDIS = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IMSK = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_ISTS = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_ICLR = 6'h20;
  localparam int CTL_RUN_BIT   = 0;
  localparam int CTL_PSEL_LSB  = 8;
  localparam int CTL_CLKEN_BIT = 16;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 16,
  localparam int SEL_W = $clog2(PRE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clk_en,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  logic [PRE_W-1:0] pre_q;
  logic             adv;

  // True when the low 'sel' bits of the prescaler are all ones
  function automatic logic tap_hit(input logic [PRE_W-1:0] pre, input logic [SEL_W-1:0] s);
    logic [PRE_W-1:0] m;
    m = ({{(PRE_W-1){1'b0}}, 1'b1} << s) - 1'b1;
    return (pre & m) == m;
  endfunction

  assign adv  = tick & clk_en;
  assign step = adv & tap_hit(pre_q, sel);

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (adv) pre_q <= pre_q + 1'b1;
  end

  // R2
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (tick && clk_en));

  // R3
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pre_q));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             run,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                   input logic [CNT_W-1:0] ceil);
    return (cur == ceil) ? '0 : cur + 1'b1;
  endfunction

  assign inc      = step & run & ~wr_en;
  assign wrap_evt = inc & (cnt_q == top);
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (inc)   cnt_q <= next_count(cnt_q, top);
  end

  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt_q == $past(wr_data));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> cnt_q == '0);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(step && run) && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] en_set,
  input  logic [NSRC-1:0] en_clr,
  input  logic [NSRC-1:0] sts_clr,
  input  logic [NSRC-1:0] src_evt,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] status,
  output logic            irq
);
  logic [NSRC-1:0] mask_q, sts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      sts_q  <= '0;
    end else begin
      mask_q <= (mask_q | en_set) & ~en_clr;
      sts_q  <= (sts_q & ~sts_clr) | src_evt;
    end
  end

  assign mask   = mask_q;
  assign status = sts_q;
  assign irq    = |(sts_q & mask_q);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    src_evt[0] |=> sts_q[0]);

  // R8
  sts_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_clr[0] && !src_evt[0]) |=> !sts_q[0]);

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en_set[0] && !en_clr[0]) |=> mask_q[0]);
endmodule

// File: rtl/rtc_prescaled.sv
module rtc_prescaled
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 16,
  localparam int SEL_W = $clog2(PRE_W),
  localparam int NSRC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             run_q, clken_q;
  logic [SEL_W-1:0] psel_q;
  logic [DATA_W-1:0] top_q, cnt;
  logic             wr, step, wrap_evt;
  logic [NSRC-1:0]  en_set, en_clr, sts_clr, src_evt, mask, status;

  assign wr      = bus_sel & bus_wr;
  assign en_set  = (wr && bus_addr == OFS_IEN)  ? bus_wdata[NSRC-1:0] : '0;
  assign en_clr  = (wr && bus_addr == OFS_IDIS) ? bus_wdata[NSRC-1:0] : '0;
  assign sts_clr = (wr && bus_addr == OFS_ICLR) ? bus_wdata[NSRC-1:0] : '0;
  assign src_evt[0] = wrap_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      clken_q <= 1'b1;
      psel_q  <= '0;
      top_q   <= '1;
    end else if (wr) begin
      if (bus_addr == OFS_CTRL) begin
        run_q   <= bus_wdata[CTL_RUN_BIT];
        clken_q <= bus_wdata[CTL_CLKEN_BIT];
        psel_q  <= bus_wdata[CTL_PSEL_LSB +: SEL_W];
      end
      if (bus_addr == OFS_TOP) top_q <= bus_wdata;
    end
  end

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_in), .clk_en(clken_q), .sel(psel_q), .step(step)
  );

  rtc_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .run(run_q),
    .wr_en(wr && bus_addr == OFS_VAL), .wr_data(bus_wdata), .top(top_q),
    .cnt(cnt), .wrap_evt(wrap_evt)
  );

  rtc_irq_regs #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr), .sts_clr(sts_clr),
    .src_evt(src_evt), .mask(mask), .status(status), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[CTL_RUN_BIT]   = run_q;
        bus_rdata[CTL_CLKEN_BIT] = clken_q;
        bus_rdata[CTL_PSEL_LSB +: SEL_W] = psel_q;
      end
      OFS_VAL:  bus_rdata = cnt;
      OFS_TOP:  bus_rdata = top_q;
      OFS_IMSK: bus_rdata[NSRC-1:0] = mask;
      OFS_ISTS: bus_rdata[NSRC-1:0] = status;
      default:  bus_rdata = '0;
    endcase
  end

  // R9
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (status[0] && mask[0]));
endmodule

// File: tb/rtc_prescaled_test.sv
`timescale 1ns/1ps
module rtc_prescaled_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_prescaled uut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural reference model
  bit          m_run, m_clken, m_mask, m_stat;
  int          m_psel, m_pre;
  logic [31:0] m_val, m_top;

  always @(posedge clk) begin
    bit pulse, wrap, w;
    if (rst) begin
      m_run = 0; m_clken = 1; m_psel = 0; m_pre = 0;
      m_val = 0; m_top = 32'hFFFF_FFFF; m_mask = 0; m_stat = 0;
    end else begin
      w = bus_sel && bus_wr;
      pulse = tick_in && m_clken && ((m_pre % (1 << m_psel)) == (1 << m_psel) - 1);
      if (tick_in && m_clken) m_pre = (m_pre + 1) % 65536;
      wrap = 0;
      if (w && bus_addr == 6'h04) m_val = bus_wdata;
      else if (pulse && m_run) begin
        if (m_val == m_top) begin m_val = 0; wrap = 1; end
        else m_val = m_val + 1;
      end
      if (w && bus_addr == 6'h00) begin
        m_run = bus_wdata[0]; m_clken = bus_wdata[16]; m_psel = int'(bus_wdata[11:8]);
      end
      if (w && bus_addr == 6'h08) m_top = bus_wdata;
      if (w && bus_addr == 6'h10 && bus_wdata[0]) m_mask = 1;
      if (w && bus_addr == 6'h14 && bus_wdata[0]) m_mask = 0;
      if (w && bus_addr == 6'h20 && bus_wdata[0]) m_stat = 0;
      if (wrap) m_stat = 1;
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return {15'd0, m_clken, 4'd0, m_psel[3:0], 7'd0, m_run};
      6'h04: return m_val;
      6'h08: return m_top;
      6'h18: return {31'd0, m_mask};
      6'h1C: return {31'd0, m_stat};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9: irq compared against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) check("R9 irq per-cycle", {31'd0, irq}, {31'd0, m_stat & m_mask});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick_in = 0;
  endtask

  task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick_in = 1;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; tick_in = 1;
      for (int j = 0; j < gap; j++) begin
        @(negedge clk);
        tick_in = 0;
      end
    end
  endtask

  task automatic rd(input logic [5:0] a, input string tag, output logic [31:0] got);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; tick_in = 0;
    #1;
    got = bus_rdata;
    check(tag, got, m_read(a));
  endtask

  initial begin
    logic [31:0] v, held;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(6'h00, "R1 ctrl", v); check("R1 ctrl literal", v, 32'h0001_0000);
    rd(6'h08, "R1 top", v);  check("R1 top literal", v, 32'hFFFF_FFFF);
    rd(6'h04, "R1 val", v);  check("R1 val literal", v, 32'h0);
    rd(6'h18, "R1 mask", v); rd(6'h1C, "R1 status", v);
    check("R1 irq", {31'd0, irq}, 32'h0);
    // R10 write-only and unmapped reads
    rd(6'h10, "R10 ien read", v); rd(6'h14, "R10 idis read", v);
    rd(6'h20, "R10 iclr read", v); rd(6'h0C, "R10 hole read", v);

    // R5 ceiling
    wr(6'h08, 32'd5);
    rd(6'h08, "R5 top", v); check("R5 top literal", v, 32'd5);

    // R2 divide by 1
    wr(6'h00, 32'h0001_0001);
    ticks(4, 0);
    rd(6'h04, "R2 val psel0", v); check("R2 val literal", v, 32'd4);
    // R4 wrap at ceiling
    ticks(3, 0);
    rd(6'h04, "R4 val after wrap", v); check("R4 val literal", v, 32'd1);
    rd(6'h1C, "R4 status", v); check("R4 status literal", v, 32'd1);

    // R7 mask set/clear and zero writes
    wr(6'h10, 32'd0); rd(6'h18, "R7 ien zero", v); check("R7 mask literal", v, 32'd0);
    wr(6'h10, 32'd1); rd(6'h18, "R7 ien one", v);  check("R7 mask set", v, 32'd1);
    check("R9 irq high", {31'd0, irq}, 32'd1);
    // R8 clear
    wr(6'h20, 32'd0); rd(6'h1C, "R8 iclr zero", v); check("R8 status kept", v, 32'd1);
    wr(6'h20, 32'd1); rd(6'h1C, "R8 iclr one", v);  check("R8 status cleared", v, 32'd0);
    check("R9 irq low", {31'd0, irq}, 32'd0);
    wr(6'h14, 32'd0); rd(6'h18, "R7 idis zero", v); check("R7 mask kept", v, 32'd1);
    wr(6'h14, 32'd1); rd(6'h18, "R7 idis one", v);  check("R7 mask cleared", v, 32'd0);

    // R2 divide by 8, continuous then sparse ticks
    wr(6'h08, 32'd1000);
    wr(6'h00, 32'h0001_0301);
    wr(6'h04, 32'd0);
    ticks(16, 0); rd(6'h04, "R2 psel3 dense", v);
    ticks(21, 1); rd(6'h04, "R2 psel3 sparse", v);
    ticks(8, 2);  rd(6'h04, "R2 psel3 gap2", v);

    // R3 frozen when clock enable clear, then when run clear
    wr(6'h00, 32'h0000_0001);
    rd(6'h04, "R3 before", held);
    ticks(10, 0); rd(6'h04, "R3 clken off", v); check("R3 clken off literal", v, held);
    wr(6'h00, 32'h0001_0000);
    ticks(10, 0); rd(6'h04, "R3 run off", v); check("R3 run off literal", v, held);

    // R6 write beats a step in the same cycle
    wr(6'h08, 32'd5);
    wr(6'h00, 32'h0001_0001);
    wr_tick(6'h04, 32'd2);
    rd(6'h04, "R6 val", v); check("R6 val literal", v, 32'd2);

    // R8 wrap in the same cycle as a clear keeps status set
    wr(6'h20, 32'd1);
    wr(6'h04, 32'd5);
    wr_tick(6'h20, 32'd1);
    rd(6'h1C, "R8 wrap vs clear", v); check("R8 wrap wins literal", v, 32'd1);
    rd(6'h04, "R4 val zero", v); check("R4 val zero literal", v, 32'd0);

    // R4 all-ones ceiling
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h20, 32'd1);
    wr(6'h04, 32'hFFFF_FFFE);
    ticks(1, 0);
    rd(6'h04, "R4 val all-ones", v); check("R4 all-ones literal", v, 32'hFFFF_FFFF);
    ticks(1, 0);
    rd(6'h04, "R4 val wrapped", v); check("R4 wrapped literal", v, 32'd0);
    rd(6'h1C, "R4 status all-ones", v); check("R4 status literal 2", v, 32'd1);

    rd(6'h3C, "R10 unmapped", v); check("R10 unmapped literal", v, 32'd0);

    @(negedge clk);
    bus_sel = 0; tick_in = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule